// File: doc/BRIEF.md
# Fired-Channel Record Packer

This block sits at the readout end of a 12-channel digitiser board. For each event it captures, in one cycle, the hit flags, 11-bit times, 12-bit charges and ADC-range select bits of all channels, together with an event identifier. It then sends a packet of 80-bit link words. The first word of the packet is a header. After it come data words, each holding two 40-bit channel records. Only the channels that fired are included, and the packer reports them from the lowest channel to the highest.

The output uses a valid/ready handshake and carries start-of-packet and end-of-packet markers. The event input has its own valid/ready pair, and `evt_ready` is high only while the packer is idle. The controller has three states:
- `ST_IDLE` waits for an event. The transition *accept* (evt_valid high) moves it to `ST_HEAD`.
- `ST_HEAD` presents the header. When the header is taken, the transition *hdr_done_empty* (no channel fired) returns to `ST_IDLE`, and *hdr_done* moves to `ST_DATA`.
- `ST_DATA` presents one data word per handshake. The transition *data_next* stays in `ST_DATA` while channels remain. The transition *data_last* returns to `ST_IDLE` once the final word is taken.

Top module: `rp_packer`

## Requirements
- R1: After reset, out_valid is 0 and evt_ready is 1.
- R2: A channel record is 40 bits wide. Counting from the MSB it holds: bits 39:36 are zero, bits 35:32 hold the channel number, bits 31:27 are zero, bits 26:16 hold the time, bit 15 holds the ADC select, bits 14:12 are zero and bits 11:0 hold the charge. Input lane i (0-based) carries channel number i+1.
- R3: Each data word holds only fired channels, in ascending order. The earlier record of the pair goes in bits 79:40 and the later record in bits 39:0.
- R4: When the number of fired channels is odd, the final data word has an all-zero second record, which is channel number 0, the empty marker.
- R5: The first word of every packet is a header with out_sop=1. It holds the event identifier in bits [8 +: EVID_W] and the data-word count in bits 3:0. All other bits of the header are zero. An accepted event presents its header in the next cycle.
- R6: The data-word count is ceil(fired/2), from 0 to 6. An event in which no channel fired produces a single header word with both out_sop and out_eop set.
- R7: out_eop is 1 only on the last word of a packet. After that word is taken, out_valid drops in the next cycle.
- R8: While out_valid=1 and out_ready=0, the packer holds out_valid, out_data, out_sop and out_eop unchanged.
- R9: evt_ready is 0 while a packet is in flight. Event inputs that change during that time have no effect on the packet being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event can be taken (idle) |
| evt_id | input | EVID_W | Event identifier |
| hit_mask | input | NCH | Per-channel fired flag |
| hit_time | input | NCH*11 | Times, lane i at [i*11 +: 11] |
| hit_charge | input | NCH*12 | Charges, lane i at [i*12 +: 12] |
| hit_adcsel | input | NCH | Per-channel ADC range select |
| out_data | output | 80 | Link word |
| out_valid | output | 1 | Link word present |
| out_ready | input | 1 | Sink takes the word |
| out_sop | output | 1 | Header word marker |
| out_eop | output | 1 | Last word marker |

## Verification
The bench drives several kinds of events:
- an empty event, which a design that counts words wrongly would end without an end-of-packet, or with an extra data word;
- single-channel and odd-sized events, where a packer that skips the padding would leave stale data in the second slot;
- the full twelve-channel event, which overflows a count field that is one bit too narrow;
- events with the top channel alone, which exposes an off-by-one in the lane-to-channel numbering.

Long and random back-pressure checks that words are not lost or duplicated while the output is stalled. Event inputs are scrambled while each packet is in flight, which catches a design that reads live inputs instead of the captured copy.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int REC_W  = 40;
    localparam int LINK_W = 80;
    localparam int TIME_W = 11;
    localparam int CHG_W  = 12;
    localparam int NUM_W  = 4;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA
    } rp_state_e;

    typedef struct packed {
        logic [3:0]        rsv_a;
        logic [NUM_W-1:0]  num;
        logic [4:0]        rsv_b;
        logic [TIME_W-1:0] tval;
        logic              sel;
        logic [2:0]        rsv_c;
        logic [CHG_W-1:0]  qval;
    } rp_rec_t;

    function automatic logic [REC_W-1:0] rp_make_rec(
        input logic [NUM_W-1:0]  num,
        input logic [TIME_W-1:0] tval,
        input logic              sel,
        input logic [CHG_W-1:0]  qval
    );
        rp_rec_t r;
        r.rsv_a = '0;
        r.num   = num;
        r.rsv_b = '0;
        r.tval  = tval;
        r.sel   = sel;
        r.rsv_c = '0;
        r.qval  = qval;
        return r;
    endfunction
endpackage

// File: rtl/rp_event_latch.sv
module rp_event_latch
    import rp_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int EVID_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  retire,
    input  logic [NCH-1:0]        retire_mask,
    input  logic [EVID_W-1:0]     in_id,
    input  logic [NCH-1:0]        in_mask,
    input  logic [NCH*TIME_W-1:0] in_time,
    input  logic [NCH*CHG_W-1:0]  in_chg,
    input  logic [NCH-1:0]        in_sel,
    output logic [EVID_W-1:0]     q_id,
    output logic [NCH-1:0]        q_pend,
    output logic [NCH*TIME_W-1:0] q_time,
    output logic [NCH*CHG_W-1:0]  q_chg,
    output logic [NCH-1:0]        q_sel,
    output logic [CNT_W-1:0]      q_words
);
    localparam int POP_W = $clog2(NCH + 1) + 1;

    logic [POP_W-1:0] pop;

    always_comb begin
        pop = '0;
        for (int i = 0; i < NCH; i++) begin
            pop = pop + POP_W'(in_mask[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_id    <= '0;
            q_pend  <= '0;
            q_time  <= '0;
            q_chg   <= '0;
            q_sel   <= '0;
            q_words <= '0;
        end else if (load) begin
            q_id    <= in_id;
            q_pend  <= in_mask;
            q_time  <= in_time;
            q_chg   <= in_chg;
            q_sel   <= in_sel;
            q_words <= CNT_W'((pop + POP_W'(1)) >> 1);
        end else if (retire) begin
            q_pend  <= q_pend & ~retire_mask;
        end
    end
endmodule

// File: rtl/rp_pair_pick.sv
module rp_pair_pick #(
    parameter int NCH   = 12,
    parameter int IDX_W = 4
) (
    input  logic [NCH-1:0]   mask,
    output logic             a_vld,
    output logic [IDX_W-1:0] a_idx,
    output logic             b_vld,
    output logic [IDX_W-1:0] b_idx,
    output logic [NCH-1:0]   used,
    output logic             drained
);
    logic [NCH-1:0] rest;

    always_comb begin
        a_vld = 1'b0;
        a_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                a_vld = 1'b1;
                a_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        rest = mask;
        if (a_vld) begin
            rest[a_idx] = 1'b0;
        end
        b_vld = 1'b0;
        b_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rest[i]) begin
                b_vld = 1'b1;
                b_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        used = '0;
        if (a_vld) used[a_idx] = 1'b1;
        if (b_vld) used[b_idx] = 1'b1;
        drained = ((mask & ~used) == '0);
    end
endmodule

// File: rtl/rp_word_build.sv
module rp_word_build
    import rp_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int EVID_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic                  sel_head,
    input  logic [EVID_W-1:0]     ev_id,
    input  logic [CNT_W-1:0]      ev_words,
    input  logic [NCH*TIME_W-1:0] ev_time,
    input  logic [NCH*CHG_W-1:0]  ev_chg,
    input  logic [NCH-1:0]        ev_sel,
    input  logic                  a_vld,
    input  logic [IDX_W-1:0]      a_idx,
    input  logic                  b_vld,
    input  logic [IDX_W-1:0]      b_idx,
    output logic [LINK_W-1:0]     word
);
    logic [TIME_W-1:0] t_lane [NCH];
    logic [CHG_W-1:0]  q_lane [NCH];
    logic [REC_W-1:0]  rec_lane [NCH];
    logic [REC_W-1:0]  rec_a, rec_b;
    logic [LINK_W-1:0] hdr;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign t_lane[g]   = ev_time[g*TIME_W +: TIME_W];
        assign q_lane[g]   = ev_chg[g*CHG_W +: CHG_W];
        assign rec_lane[g] = rp_make_rec(NUM_W'(g + 1), t_lane[g], ev_sel[g], q_lane[g]);
    end

    always_comb begin
        rec_a = '0;
        rec_b = '0;
        for (int i = 0; i < NCH; i++) begin
            if (a_vld && a_idx == IDX_W'(i)) rec_a = rec_lane[i];
            if (b_vld && b_idx == IDX_W'(i)) rec_b = rec_lane[i];
        end
    end

    always_comb begin
        hdr = '0;
        hdr[CNT_W-1:0]   = ev_words;
        hdr[8 +: EVID_W] = ev_id;
    end

    assign word = sel_head ? hdr : {rec_a, rec_b};
endmodule

// File: rtl/rp_packer.sv
module rp_packer
    import rp_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int EVID_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_valid,
    output logic                  evt_ready,
    input  logic [EVID_W-1:0]     evt_id,
    input  logic [NCH-1:0]        hit_mask,
    input  logic [NCH*11-1:0]     hit_time,
    input  logic [NCH*12-1:0]     hit_charge,
    input  logic [NCH-1:0]        hit_adcsel,
    output logic [79:0]           out_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_sop,
    output logic                  out_eop
);
    localparam int IDX_W = $clog2(NCH);

    rp_state_e state_q, state_d;

    logic                  load, retire;
    logic [EVID_W-1:0]     ev_id;
    logic [NCH-1:0]        ev_pend, ev_sel, used;
    logic [NCH*TIME_W-1:0] ev_time;
    logic [NCH*CHG_W-1:0]  ev_chg;
    logic [CNT_W-1:0]      ev_words;
    logic                  a_vld, b_vld, drained;
    logic [IDX_W-1:0]      a_idx, b_idx;

    rp_event_latch #(.NCH(NCH), .EVID_W(EVID_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .retire      (retire),
        .retire_mask (used),
        .in_id       (evt_id),
        .in_mask     (hit_mask),
        .in_time     (hit_time),
        .in_chg      (hit_charge),
        .in_sel      (hit_adcsel),
        .q_id        (ev_id),
        .q_pend      (ev_pend),
        .q_time      (ev_time),
        .q_chg       (ev_chg),
        .q_sel       (ev_sel),
        .q_words     (ev_words)
    );

    rp_pair_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
        .mask    (ev_pend),
        .a_vld   (a_vld),
        .a_idx   (a_idx),
        .b_vld   (b_vld),
        .b_idx   (b_idx),
        .used    (used),
        .drained (drained)
    );

    rp_word_build #(.NCH(NCH), .EVID_W(EVID_W), .IDX_W(IDX_W)) u_build (
        .sel_head (state_q == ST_HEAD),
        .ev_id    (ev_id),
        .ev_words (ev_words),
        .ev_time  (ev_time),
        .ev_chg   (ev_chg),
        .ev_sel   (ev_sel),
        .a_vld    (a_vld),
        .a_idx    (a_idx),
        .b_vld    (b_vld),
        .b_idx    (b_idx),
        .word     (out_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (evt_valid) state_d = ST_HEAD;
            ST_HEAD: if (out_ready) state_d = (ev_words == '0) ? ST_IDLE : ST_DATA;
            ST_DATA: if (out_ready && drained) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        evt_ready = 1'b0;
        out_valid = 1'b0;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        load      = 1'b0;
        retire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                evt_ready = 1'b1;
                load      = evt_valid;
            end
            ST_HEAD: begin
                out_valid = 1'b1;
                out_sop   = 1'b1;
                out_eop   = (ev_words == '0);
            end
            ST_DATA: begin
                out_valid = 1'b1;
                out_eop   = drained;
                retire    = out_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rp_packer_chk.sv
module rp_packer_chk #(
    parameter int NCH    = 12,
    parameter int EVID_W = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic        evt_ready,
    input logic [79:0] out_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_sop,
    input logic        out_eop
);
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !evt_ready);

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sop |-> out_data[79:76] == 4'h0 && out_data[71:67] == 5'h0 &&
        out_data[54:52] == 3'h0 && out_data[39:36] == 4'h0 && out_data[31:27] == 5'h0 &&
        out_data[14:12] == 3'h0 && out_data[75:72] <= 4'(NCH) && out_data[75:72] != 4'h0);

    assert_pad_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sop && out_data[35:32] == 4'h0 |-> out_data[39:0] == 40'h0 && out_eop);

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sop && out_data[35:32] != 4'h0 |-> out_data[75:72] < out_data[35:32]);

    assert_hdr_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> out_data[3:0] <= 4'((NCH + 1) / 2) && out_data[7:4] == 4'h0 &&
        (out_eop == (out_data[3:0] == 4'h0)));

    assert_accept_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_ready |=> out_valid && out_sop);

    assert_eop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eop |=> !out_valid);
endmodule

bind rp_packer rp_packer_chk #(.NCH(NCH), .EVID_W(EVID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/sim_rp_packer.sv
module sim_rp_packer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 12;
    localparam int EVID_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic              evt_ready;
    logic [EVID_W-1:0] evt_id = '0;
    logic [NCH-1:0]    hit_mask = '0;
    logic [NCH*11-1:0] hit_time = '0;
    logic [NCH*12-1:0] hit_charge = '0;
    logic [NCH-1:0]    hit_adcsel = '0;
    logic [79:0]       out_data;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic              out_sop;
    logic              out_eop;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int ready_mode = 0;
    bit model_on = 0;
    bit finished = 0;
    logic [81:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rp_packer #(.NCH(NCH), .EVID_W(EVID_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_ready  (evt_ready),
        .evt_id     (evt_id),
        .hit_mask   (hit_mask),
        .hit_time   (hit_time),
        .hit_charge (hit_charge),
        .hit_adcsel (hit_adcsel),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural expectation of one packet from the event inputs now applied.
    task automatic push_packet();
        logic [39:0] recs[$];
        logic [79:0] hdr;
        int nw;
        for (int i = 0; i < NCH; i++) begin
            if (hit_mask[i]) begin
                recs.push_back({4'h0, 4'(i + 1), 5'h0, hit_time[i*11 +: 11], hit_adcsel[i], 3'h0, hit_charge[i*12 +: 12]});
            end
        end
        nw = (recs.size() + 1) / 2;
        hdr = '0;
        hdr[3:0] = 4'(nw);
        hdr[8 +: EVID_W] = evt_id;
        exp_q.push_back({1'b1, nw == 0, hdr});
        for (int w = 0; w < nw; w++) begin
            logic [39:0] lo;
            lo = (2 * w + 1 < recs.size()) ? recs[2 * w + 1] : 40'h0;
            exp_q.push_back({1'b0, w == nw - 1, recs[2 * w], lo});
        end
    endtask

    // Reference compare on every clock, sampled mid-cycle.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(evt_ready == (exp_q.size() == 0), "R9", 80'(evt_ready), 80'(exp_q.size() == 0));
            check(out_valid == (exp_q.size() != 0), "R8", 80'(out_valid), 80'(exp_q.size() != 0));
            if (out_valid && exp_q.size() != 0) begin
                if (exp_q[0][81]) begin
                    check(out_data == exp_q[0][79:0], exp_q[0][3:0] == 0 ? "R6" : "R5", out_data, exp_q[0][79:0]);
                end else if (exp_q[0][39:0] == 40'h0) begin
                    check(out_data == exp_q[0][79:0], "R4", out_data, exp_q[0][79:0]);
                end else begin
                    check(out_data == exp_q[0][79:0], "R3", out_data, exp_q[0][79:0]);
                end
                check(out_sop == exp_q[0][81], "R5", 80'(out_sop), 80'(exp_q[0][81]));
                check(out_eop == exp_q[0][80], "R7", 80'(out_eop), 80'(exp_q[0][80]));
                if (out_ready) void'(exp_q.pop_front());
            end
            if (evt_valid && evt_ready) push_packet();
        end
    end

    always begin
        @(posedge clk);
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 3) != 0;
            default: out_ready = 1'b0;
        endcase
    end

    always begin
        @(posedge clk);
        cycles++;
        if (cycles > 100000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic scramble();
        evt_id     = 16'($urandom);
        hit_mask   = 12'($urandom);
        hit_adcsel = 12'($urandom);
        for (int i = 0; i < NCH; i++) begin
            hit_time[i*11 +: 11]   = 11'($urandom);
            hit_charge[i*12 +: 12] = 12'($urandom);
        end
    endtask

    task automatic send(input logic [NCH-1:0] m);
        @(posedge clk);
        #1;
        scramble();
        hit_mask  = m;
        evt_valid = 1'b1;
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        @(posedge clk);
        #1;
        evt_valid = 1'b0;
        scramble();  // R9: changes while busy must not reach the packet
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0 || !evt_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 80'(out_valid), 80'h0);
        check(evt_ready == 1'b1, "R1", 80'(evt_ready), 80'h1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_on = 1;

        send(12'h000);                       // R6 empty event
        drain();
        send(12'h001);                       // R4 single channel
        drain();
        send(12'hFFF);                       // R6 full packet
        drain();
        send(12'h800);                       // R2 top lane numbering
        drain();
        send(12'h555);
        drain();

        // R2 hand-built record for lane 4 (channel 5)
        @(posedge clk);
        #1;
        hit_mask = 12'h010;
        evt_id = 16'h1234;
        hit_time[4*11 +: 11] = 11'h5A3;
        hit_charge[4*12 +: 12] = 12'hABC;
        hit_adcsel[4] = 1'b1;
        evt_valid = 1'b1;
        @(posedge clk);
        #1;
        evt_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_data[79:40] == {4'h0, 4'h5, 5'h0, 11'h5A3, 1'b1, 3'h0, 12'hABC}, "R2",
              {40'h0, out_data[79:40]}, {40'h0, 4'h0, 4'h5, 5'h0, 11'h5A3, 1'b1, 3'h0, 12'hABC});
        drain();

        // R8 long stall then release
        ready_mode = 2;
        send(12'hFFF);
        repeat (20) @(posedge clk);
        ready_mode = 0;
        drain();

        // Random traffic with back-pressure and back-to-back offers
        ready_mode = 1;
        for (int k = 0; k < 300; k++) begin
            send(12'($urandom));
        end
        drain();
        ready_mode = 0;
        drain();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule